// File: doc/BRIEF.md
# SPI Co-processor Transaction Sequencer

This block is the host-side engine that runs one half-duplex request/response exchange with a co-processor over SPI. It pulls slave select low and sends a command frame, byte by byte, from a local command buffer. It then keeps sending idle bytes (0xFF) until the co-processor returns something other than 0xFF. That byte opens the response. The engine uses the first one or two response bytes to work out how long the response is, clocks in exactly that many bytes, checks the closing terminator and releases slave select.

The engine works on whole bytes. Each byte exchange is a request/acknowledge pair with a byte shifter outside the block. A millisecond tick input drives two guards. One ends a wait phase that never produces a response. The other holds slave select high for a minimum gap before the next transaction. A start request made while the engine is busy, or during the gap, is held and served as soon as the engine is free. When the engine finishes, a one-cycle done pulse carries an error code and the stored response length. The response bytes can then be read from the response buffer.

Top module: `spi_txn_seq`

## Requirements
- R1: After reset, ss_n is 1, and busy, done and xfer_go are all 0.
- R2: A start while idle drives ss_n low and sets busy. The engine then sends command-buffer bytes 0 to cmd_len-1, in order, with one xfer_go per byte. Bytes received during the command phase are ignored, whatever their value.
- R3: After the last command byte, the engine sends 0xFF. The first received byte that is not 0xFF is the response's first byte and is stored at response address 0.
- R4: The response length in bytes is set by its first byte. A first byte in 0x00..0x04 gives 3 bytes. A first byte in 0x81..0xC1 gives 2 bytes. A first byte of 0xFD or 0xFE gives the second byte plus 3. The engine sends 0xFF for each response byte, makes exactly that many transfers and then releases ss_n. rsp_len reports the byte count.
- R5: If the final response byte is not 0xA7, err is 2 (bad terminator). If it is 0xA7, err is 0.
- R6: If the first byte is 0xFD or 0xFE and the second byte is greater than 133, the engine stops after 2 bytes with err 3 and rsp_len 2.
- R7: Any other first byte (not 0xFF) stops the engine after 1 byte, with err 4 and rsp_len 1.
- R8: If TIMEOUT_MS millisecond ticks pass in the wait phase with no byte other than 0xFF, the engine ends once no transfer is outstanding. It then reports err 1 and rsp_len 0.
- R9: done is high for exactly one cycle per transaction, and ss_n is already high in that cycle. err is non-zero only while done is high.
- R10: After release, ss_n stays high until GAP_MS+1 millisecond ticks have been counted.
- R11: A start seen while busy is held and begins a transaction as soon as the gap ends. Several starts made during one busy period give only one further transaction. busy stays high through the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one transaction |
| cmd_len | input | 8 | Command length in bytes (2..136), sampled when a transaction begins |
| cmd_we | input | 1 | Command buffer write enable |
| cmd_waddr | input | 8 | Command buffer write address |
| cmd_wdata | input | 8 | Command buffer write data |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ss_n | output | 1 | Slave select, active low |
| xfer_go | output | 1 | One-cycle request to the byte shifter |
| xfer_tx | output | 8 | Byte to send, valid with xfer_go |
| xfer_done | input | 1 | Byte shifter finished the exchange |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |
| rsp_raddr | input | 8 | Response buffer read address |
| rsp_rdata | output | 8 | Response buffer read data (combinational) |
| rsp_len | output | 8 | Bytes stored by the last transaction |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 3 | 0 ok, 1 timeout, 2 bad terminator, 3 oversize, 4 unknown type |
| busy | output | 1 | Transaction or spacing gap in progress |

## Verification
ss_n falls one edge after start is sampled, so the bench checks it at the following falling edge. done rises one edge after the xfer_done of the last byte. The bench polls done at falling edges and reads the response buffer only after that. The timeout is measured in ticks from the final command byte's acknowledge; the bench allows a window of two ticks for a transfer that is still in flight. After each transaction the bench waits longer than the gap, then confirms that the transfer count has not changed and that ss_n is high.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;
    localparam logic [7:0] TERM_BYTE = 8'hA7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_CMD,
        ST_WAIT,
        ST_RSP
    } seq_state_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_TIMEOUT  = 3'd1,
        ERR_TERM     = 3'd2,
        ERR_OVERSIZE = 3'd3,
        ERR_BADTYPE  = 3'd4
    } seq_err_e;

    typedef enum logic [1:0] {
        K_ERRCODE,
        K_SHORT,
        K_PAYLOAD,
        K_INVALID
    } rsp_kind_e;

    // Kind of response frame, decided by its first byte.
    function automatic rsp_kind_e classify(input logic [7:0] b);
        if (b <= 8'h04)
            return K_ERRCODE;
        else if (b >= 8'h81 && b <= 8'hC1)
            return K_SHORT;
        else if (b == 8'hFD || b == 8'hFE)
            return K_PAYLOAD;
        else
            return K_INVALID;
    endfunction

    // Total frame size for the kinds whose size is fixed; 0 when a length byte decides.
    function automatic logic [7:0] fixed_total(input rsp_kind_e k);
        case (k)
            K_ERRCODE: return 8'd3;
            K_SHORT:   return 8'd2;
            default:   return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/spi_txn_bytebuf.sv
module spi_txn_bytebuf #(
    parameter int DEPTH = 136,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH))
            mem[waddr] <= wdata;
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;

endmodule

// File: rtl/spi_txn_mstimer.sv
module spi_txn_mstimer #(
    parameter int LIMIT = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en && tick && (cnt != CW'(LIMIT)))
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT));

    // R8 / R10: the count saturates and never passes its limit
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= LIMIT);

    // R10: a clear always restarts the interval
    a_r10_clear_restarts: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/spi_txn_rsp_eval.sv
module spi_txn_rsp_eval
    import spi_txn_pkg::*;
#(
    parameter int LW          = 8,
    parameter int PAYLOAD_MAX = 133
) (
    input  logic [LW-1:0] idx,
    input  logic [LW-1:0] total,
    input  rsp_kind_e     kind,
    input  logic [7:0]    rx,
    output logic [LW-1:0] total_nxt,
    output logic          last,
    output logic          oversize
);

    logic len_byte;

    always_comb begin
        len_byte  = (idx == LW'(1)) && (kind == K_PAYLOAD);
        oversize  = len_byte && (int'(rx) > PAYLOAD_MAX);
        total_nxt = len_byte ? (LW'(rx) + LW'(3)) : total;
        last      = (LW'(idx + 1'b1) == total_nxt);
    end

endmodule

// File: rtl/spi_txn_seq.sv
module spi_txn_seq
    import spi_txn_pkg::*;
#(
    parameter int FRAME_MAX   = 136,
    parameter int PAYLOAD_MAX = 133,
    parameter int TIMEOUT_MS  = 300,
    parameter int GAP_MS      = 1,
    parameter int AW          = $clog2(FRAME_MAX),
    parameter int LW          = $clog2(FRAME_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] cmd_len,
    input  logic          cmd_we,
    input  logic [AW-1:0] cmd_waddr,
    input  logic [7:0]    cmd_wdata,
    input  logic          ms_tick,
    output logic          ss_n,
    output logic          xfer_go,
    output logic [7:0]    xfer_tx,
    input  logic          xfer_done,
    input  logic [7:0]    xfer_rx,
    input  logic [AW-1:0] rsp_raddr,
    output logic [7:0]    rsp_rdata,
    output logic [LW-1:0] rsp_len,
    output logic          done,
    output logic [2:0]    err,
    output logic          busy
);

    localparam int GAP_TICKS = GAP_MS + 1;

    seq_state_e    state;
    rsp_kind_e     kind_q;
    seq_err_e      err_q;
    logic [LW-1:0] idx, total_q, cmd_len_q, rsp_len_q;
    logic          pending, inflight, go_q, done_q, ss_q;
    logic [7:0]    tx_q;

    logic          begin_now, got_byte;
    logic          tmo_expired, gap_expired;
    logic [7:0]    cmd_rdata;
    logic          rsp_we;
    logic [AW-1:0] rsp_waddr;
    logic [LW-1:0] total_nxt;
    logic          rsp_last, rsp_oversize;
    rsp_kind_e     rx_kind;

    assign got_byte  = inflight && xfer_done;
    assign begin_now = (state == ST_IDLE) && (start || pending);
    assign rx_kind   = classify(xfer_rx);

    // Command storage, read at the current byte index.
    spi_txn_bytebuf #(.DEPTH(FRAME_MAX), .AW(AW)) u_cmd_buf (
        .clk   (clk),
        .we    (cmd_we),
        .waddr (cmd_waddr),
        .wdata (cmd_wdata),
        .raddr (AW'(idx)),
        .rdata (cmd_rdata)
    );

    // Response storage: written as bytes arrive, read by the host.
    always_comb begin
        rsp_we    = 1'b0;
        rsp_waddr = AW'(idx);
        if (got_byte && state == ST_WAIT && xfer_rx != IDLE_BYTE) begin
            rsp_we    = 1'b1;
            rsp_waddr = '0;
        end else if (got_byte && state == ST_RSP) begin
            rsp_we    = 1'b1;
        end
    end

    spi_txn_bytebuf #(.DEPTH(FRAME_MAX), .AW(AW)) u_rsp_buf (
        .clk   (clk),
        .we    (rsp_we),
        .waddr (rsp_waddr),
        .wdata (xfer_rx),
        .raddr (rsp_raddr),
        .rdata (rsp_rdata)
    );

    spi_txn_rsp_eval #(.LW(LW), .PAYLOAD_MAX(PAYLOAD_MAX)) u_eval (
        .idx       (idx),
        .total     (total_q),
        .kind      (kind_q),
        .rx        (xfer_rx),
        .total_nxt (total_nxt),
        .last      (rsp_last),
        .oversize  (rsp_oversize)
    );

    spi_txn_mstimer #(.LIMIT(TIMEOUT_MS)) u_wait_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_WAIT),
        .en      (state == ST_WAIT),
        .tick    (ms_tick),
        .expired (tmo_expired)
    );

    spi_txn_mstimer #(.LIMIT(GAP_TICKS)) u_gap_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_GAP),
        .en      (state == ST_GAP),
        .tick    (ms_tick),
        .expired (gap_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            kind_q    <= K_INVALID;
            err_q     <= ERR_NONE;
            idx       <= '0;
            total_q   <= '0;
            cmd_len_q <= '0;
            rsp_len_q <= '0;
            pending   <= 1'b0;
            inflight  <= 1'b0;
            go_q      <= 1'b0;
            done_q    <= 1'b0;
            ss_q      <= 1'b1;
            tx_q      <= IDLE_BYTE;
        end else begin
            go_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= ERR_NONE;
            pending <= begin_now ? 1'b0 : (pending | start);
            if (got_byte)
                inflight <= 1'b0;

            case (state)
                ST_IDLE: begin
                    if (begin_now) begin
                        state     <= ST_CMD;
                        ss_q      <= 1'b0;
                        cmd_len_q <= cmd_len;
                        idx       <= '0;
                    end
                end

                ST_GAP: begin
                    if (gap_expired)
                        state <= ST_IDLE;
                end

                ST_CMD: begin
                    if (!inflight) begin
                        go_q     <= 1'b1;
                        tx_q     <= cmd_rdata;
                        inflight <= 1'b1;
                    end else if (xfer_done) begin
                        if (LW'(idx + 1'b1) >= cmd_len_q) begin
                            state <= ST_WAIT;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end

                ST_WAIT: begin
                    if (got_byte && xfer_rx != IDLE_BYTE) begin
                        kind_q <= rx_kind;
                        if (rx_kind == K_INVALID) begin
                            state     <= ST_GAP;
                            ss_q      <= 1'b1;
                            done_q    <= 1'b1;
                            err_q     <= ERR_BADTYPE;
                            rsp_len_q <= LW'(1);
                        end else begin
                            state   <= ST_RSP;
                            idx     <= LW'(1);
                            total_q <= LW'(fixed_total(rx_kind));
                        end
                    end else if (tmo_expired && (got_byte || !inflight)) begin
                        state     <= ST_GAP;
                        ss_q      <= 1'b1;
                        done_q    <= 1'b1;
                        err_q     <= ERR_TIMEOUT;
                        rsp_len_q <= '0;
                    end else if (!inflight) begin
                        go_q     <= 1'b1;
                        tx_q     <= IDLE_BYTE;
                        inflight <= 1'b1;
                    end
                end

                ST_RSP: begin
                    if (!inflight) begin
                        go_q     <= 1'b1;
                        tx_q     <= IDLE_BYTE;
                        inflight <= 1'b1;
                    end else if (xfer_done) begin
                        if (rsp_oversize) begin
                            state     <= ST_GAP;
                            ss_q      <= 1'b1;
                            done_q    <= 1'b1;
                            err_q     <= ERR_OVERSIZE;
                            rsp_len_q <= LW'(2);
                        end else if (rsp_last) begin
                            state     <= ST_GAP;
                            ss_q      <= 1'b1;
                            done_q    <= 1'b1;
                            err_q     <= (xfer_rx == TERM_BYTE) ? ERR_NONE : ERR_TERM;
                            rsp_len_q <= LW'(idx + 1'b1);
                        end else begin
                            total_q <= total_nxt;
                            idx     <= idx + 1'b1;
                        end
                    end
                end

                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ss_n    = ss_q;
    assign xfer_go = go_q;
    assign xfer_tx = tx_q;
    assign done    = done_q;
    assign err     = err_q;
    assign rsp_len = rsp_len_q;
    assign busy    = (state != ST_IDLE);

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: slave select is already released when done is reported
    a_r9_release_with_done: assert property (@(posedge clk) disable iff (rst)
        done |-> ss_n);

    // R9: the error code is only presented together with done
    a_r9_err_gated: assert property (@(posedge clk) disable iff (rst)
        !done |-> (err == 3'd0));

    // R2: byte requests only happen inside an active select
    a_r2_go_in_select: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> !ss_n);

    // R3 / R4: outside the command phase only the idle fill byte is sent
    a_r3_fill_byte: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && state != ST_CMD) |-> (xfer_tx == IDLE_BYTE));

    // R4: one byte request per exchange
    a_r4_single_request: assert property (@(posedge clk) disable iff (rst)
        xfer_go |=> !xfer_go);

    // R4: a reported length never exceeds the largest frame
    a_r4_len_bounded: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(rsp_len) <= FRAME_MAX));

    // R10: slave select stays high through the spacing gap
    a_r10_gap_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> ss_n);

    // R11: a held request starts a transaction once the engine is idle
    a_r11_pending_served: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && pending) |=> !ss_n);

endmodule

// File: tb/spi_txn_seq_bench.sv
module spi_txn_seq_bench;

    localparam int TMO      = 300;
    localparam int GAP      = 1;
    localparam int TICK_CYC = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [7:0] cmd_len;
    logic       cmd_we;
    logic [7:0] cmd_waddr, cmd_wdata;
    logic       ms_tick;
    logic       ss_n, xfer_go, xfer_done, done, busy;
    logic [7:0] xfer_tx, xfer_rx, rsp_raddr, rsp_rdata, rsp_len;
    logic [2:0] err;

    always #2 clk = ~clk;

    spi_txn_seq #(.TIMEOUT_MS(TMO), .GAP_MS(GAP)) u_spi_txn_seq (
        .clk(clk), .rst(rst), .start(start), .cmd_len(cmd_len),
        .cmd_we(cmd_we), .cmd_waddr(cmd_waddr), .cmd_wdata(cmd_wdata),
        .ms_tick(ms_tick), .ss_n(ss_n), .xfer_go(xfer_go), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx), .rsp_raddr(rsp_raddr),
        .rsp_rdata(rsp_rdata), .rsp_len(rsp_len), .done(done), .err(err),
        .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] cmd_arr [0:135];
    int         cmd_n = 2;
    logic [7:0] scr [0:199];
    int         scr_n = 0;
    logic [7:0] mosi_log [0:1023];
    int         log_n = 0;
    int         tick_total = 0;
    int         tick_mark = 0;
    int         exp_err, exp_len, exp_w;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Millisecond tick source
    initial begin
        ms_tick = 1'b0;
        forever begin
            repeat (TICK_CYC - 1) @(negedge clk);
            ms_tick = 1'b1;
            tick_total++;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    end

    // Byte shifter model: garbage during command, then the script, then 0xFF
    initial begin
        xfer_done = 1'b0;
        xfer_rx   = 8'h00;
        forever begin
            @(negedge clk);
            if (xfer_go) begin
                if (log_n < 1024) mosi_log[log_n] = xfer_tx;
                if (log_n == cmd_n - 1) tick_mark = tick_total;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                if (log_n < cmd_n)
                    xfer_rx = 8'h30 + 8'(log_n[3:0]);
                else if (log_n - cmd_n < scr_n)
                    xfer_rx = scr[log_n - cmd_n];
                else
                    xfer_rx = 8'hFF;
                log_n++;
                xfer_done = 1'b1;
                @(negedge clk);
                xfer_done = 1'b0;
            end
        end
    end

    // Global watchdog
    initial begin
        repeat (190000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic scr_push(input logic [7:0] b);
        scr[scr_n] = b;
        scr_n++;
    endtask

    task automatic load_cmd();
        for (int i = 0; i < cmd_n; i++) begin
            @(negedge clk);
            cmd_we = 1'b1; cmd_waddr = 8'(i); cmd_wdata = cmd_arr[i];
        end
        @(negedge clk);
        cmd_we = 1'b0;
        cmd_len = 8'(cmd_n);
    endtask

    task automatic wait_done();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 20000);
        check(done == 1'b1, "R9 done pulse seen", int'(done), 1);
    endtask

    // Expected outcome from the framing rules (R3..R8)
    task automatic compute_expect();
        int w = 0;
        int tot = 0;
        logic [7:0] b0, b1;
        while (w < scr_n && scr[w] == 8'hFF) w++;
        exp_w = w;
        if (w >= scr_n) begin
            exp_err = 1; exp_len = 0;
            return;
        end
        b0 = scr[w];
        b1 = (w + 1 < scr_n) ? scr[w + 1] : 8'hFF;
        if (b0 <= 8'h04) tot = 3;
        else if (b0 >= 8'h81 && b0 <= 8'hC1) tot = 2;
        else if (b0 == 8'hFD || b0 == 8'hFE) begin
            if (b1 > 8'd133) begin
                exp_err = 3; exp_len = 2;
                return;
            end
            tot = int'(b1) + 3;
        end else begin
            exp_err = 4; exp_len = 1;
            return;
        end
        exp_len = tot;
        exp_err = ((w + tot - 1 < scr_n) && scr[w + tot - 1] == 8'hA7) ? 0 : 2;
    endtask

    task automatic run_and_check(input string tag);
        int bad;
        int t;
        compute_expect();
        log_n = 0;
        load_cmd();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(ss_n == 1'b0 && busy == 1'b1, {"R2 select and busy ", tag}, int'({ss_n, busy}), 1);
        wait_done();
        check(int'(err) == exp_err, {"R5 R6 R7 R8 err ", tag}, int'(err), exp_err);
        check(int'(rsp_len) == exp_len, {"R4 rsp_len ", tag}, int'(rsp_len), exp_len);
        check(ss_n == 1'b1, {"R9 released at done ", tag}, int'(ss_n), 1);
        if (exp_err == 1) begin
            t = tick_total - tick_mark;
            check(t >= TMO && t <= TMO + 2, {"R8 timeout tick count ", tag}, t, TMO);
        end
        bad = 0;
        for (int i = 0; i < exp_len; i++) begin
            rsp_raddr = 8'(i);
            #1;
            if (rsp_rdata !== scr[exp_w + i]) bad++;
        end
        check(bad == 0, {"R3 R4 stored response ", tag}, bad, 0);
        bad = 0;
        for (int i = 0; i < log_n && i < 1024; i++) begin
            if (i < cmd_n) begin
                if (mosi_log[i] !== cmd_arr[i]) bad++;
            end else if (mosi_log[i] !== 8'hFF) bad++;
        end
        check(bad == 0, {"R2 R3 sent bytes ", tag}, bad, 0);
        repeat (40) @(negedge clk);
        if (exp_err != 1)
            check(log_n == cmd_n + exp_w + exp_len, {"R4 transfer count ", tag},
                  log_n, cmd_n + exp_w + exp_len);
        check(ss_n == 1'b1 && done == 1'b0, {"R9 quiet after end ", tag}, int'({ss_n, done}), 2);
    endtask

    task automatic set_cmd(input int n);
        cmd_n = n;
        cmd_arr[0] = 8'(($urandom_range(0, 253)));
        for (int i = 1; i < n; i++) cmd_arr[i] = 8'($urandom_range(0, 255));
    endtask

    task automatic fill_ff(input int w);
        scr_n = 0;
        for (int i = 0; i < w; i++) scr_push(8'hFF);
    endtask

    initial begin
        int t;
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; cmd_len = 8'd2; cmd_we = 1'b0;
        cmd_waddr = 8'd0; cmd_wdata = 8'd0; rsp_raddr = 8'd0;
        repeat (5) @(negedge clk);
        check(ss_n == 1'b1, "R1 ss_n after reset", int'(ss_n), 1);
        check(busy == 1'b0 && done == 1'b0 && xfer_go == 1'b0, "R1 idle outputs after reset",
              int'({busy, done, xfer_go}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // Version response after a few fill bytes
        set_cmd(2); cmd_arr[0] = 8'h0A; cmd_arr[1] = 8'hA7;
        fill_ff(3); scr_push(8'h82); scr_push(8'hA7);
        run_and_check("R3 R4 version");

        // Status response, immediate
        set_cmd(2); fill_ff(0); scr_push(8'hC1); scr_push(8'hA7);
        run_and_check("R4 status");

        // Error-code response
        set_cmd(5); fill_ff(2); scr_push(8'h02); scr_push(8'h00); scr_push(8'hA7);
        run_and_check("R4 errcode");

        // Payload response with length 4
        set_cmd(7); fill_ff(1);
        scr_push(8'hFE); scr_push(8'h04);
        for (int i = 0; i < 4; i++) scr_push(8'h10 + 8'(i));
        scr_push(8'hA7);
        run_and_check("R4 payload");

        // Largest payload: 133 bytes, 136-byte frame, 136-byte command
        set_cmd(136); fill_ff(0);
        scr_push(8'hFD); scr_push(8'd133);
        for (int i = 0; i < 133; i++) scr_push(8'($urandom_range(0, 255)));
        scr_push(8'hA7);
        run_and_check("R4 max frame");

        // Oversize length byte
        set_cmd(3); fill_ff(1); scr_push(8'hFE); scr_push(8'd134); scr_push(8'hA7);
        run_and_check("R6 oversize");

        // Bad terminators
        set_cmd(2); fill_ff(0); scr_push(8'hFE); scr_push(8'd0); scr_push(8'h00);
        run_and_check("R5 bad term zero");
        set_cmd(2); fill_ff(2); scr_push(8'h81); scr_push(8'hFF);
        run_and_check("R5 bad term ff");

        // Unknown first byte
        set_cmd(4); fill_ff(1); scr_push(8'h10); scr_push(8'hA7);
        run_and_check("R7 unknown type");

        // Wait timeout
        set_cmd(2); fill_ff(0);
        run_and_check("R8 timeout");

        // Starts during busy period are held; spacing respected (R10, R11)
        set_cmd(2); cmd_arr[0] = 8'h0B; fill_ff(1); scr_push(8'hC0); scr_push(8'hA7);
        log_n = 0;
        load_cmd();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R11 busy while running", int'(busy), 1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        t = tick_total;
        log_n = 0;
        @(negedge clk);
        check(busy == 1'b1 && ss_n == 1'b1, "R11 busy during gap", int'({busy, ss_n}), 3);
        begin
            int n = 0;
            while (ss_n == 1'b1 && n < 2000) begin
                @(negedge clk);
                n++;
            end
        end
        check(tick_total - t >= GAP + 1, "R10 spacing ticks", tick_total - t, GAP + 1);
        check(ss_n == 1'b0, "R11 held start served", int'(ss_n), 0);
        wait_done();
        check(int'(err) == 0 && int'(rsp_len) == 2, "R11 second transaction result",
              int'(err), 0);
        repeat (100) @(negedge clk);
        check(ss_n == 1'b1 && busy == 1'b0 && log_n == 5, "R11 only one extra transaction",
              log_n, 5);

        // Random transactions
        for (int k = 0; k < 25; k++) begin
            int kind;
            int plen;
            set_cmd($urandom_range(2, 24));
            fill_ff($urandom_range(0, 6));
            kind = $urandom_range(0, 4);
            case (kind)
                0: scr_push(8'h81 + 8'($urandom_range(0, 62)));
                1: scr_push(8'hC0 + 8'($urandom_range(0, 1)));
                2: begin
                    scr_push(8'($urandom_range(0, 4)));
                    scr_push(8'($urandom_range(0, 255)));
                end
                default: begin
                    scr_push($urandom_range(0, 1) == 1 ? 8'hFE : 8'hFD);
                    plen = $urandom_range(0, 30);
                    scr_push(8'(plen));
                    for (int i = 0; i < plen; i++) scr_push(8'($urandom_range(0, 255)));
                end
            endcase
            scr_push($urandom_range(0, 5) == 0 ? 8'($urandom_range(0, 166)) : 8'hA7);
            run_and_check($sformatf("R4 R5 random %0d", k));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule